// File: doc/BRIEF.md
# Dual Data Pointer Register Unit

This block keeps two 16-bit data pointers and a one-bit select register for an 8-bit microcontroller core. Software reaches the pointer bytes and the select register as special-function registers at five byte addresses. The data-memory address path takes the active pointer from the block. The core can also increment the active pointer, load all 16 bits of it at once, or flip the select bit.

Every operation that involves a pointer acts on the currently selected pointer only. A block move can therefore keep its source address in one pointer and its destination in the other. Flipping the select bit between accesses switches from one to the other in a single operation, so no address has to be saved or restored.

Top module: `dual_pointer_unit`

## Requirements
- R1: After a synchronous reset both pointers are 0000h, the select bit is 0, `active_ptr` is 0000h and `sfr_rdata`/`sfr_hit` are 0.
- R2: An SFR write to 82h sets the low byte of pointer 0, 83h its high byte, 84h the low byte of pointer 1 and 85h its high byte. A read with `sfr_re` at one of these addresses returns that byte on `sfr_rdata` one clock later, with `sfr_hit` high.
- R3: At address 86h only bit 0 is stored, as the select bit. Bits 7..1 always read as 0, and a write to them has no effect.
- R4: `active_ptr` equals pointer 0 when the select bit is 0 and pointer 1 when it is 1.
- R5: `ptr_inc` adds one to the selected pointer only. The carry passes from the low byte into the high byte, and FFFFh wraps to 0000h.
- R6: `ptr_load` writes both bytes of the selected pointer from `load_val` in one clock and leaves the other pointer unchanged. If `ptr_load` and `ptr_inc` are both high, the load wins.
- R7: `sel_toggle` inverts the select bit. Operations in the same clock still use the old selection.
- R8: If an SFR write to a byte of a pointer falls in the same clock as an increment or load of that pointer, only the SFR write takes effect. The other byte of that pointer holds its value.
- R9: A read at any address other than 82h..86h returns `sfr_rdata` = 0 with `sfr_hit` low. When `sfr_re` is low, both outputs are 0 in the next clock.
- R10: An SFR write to 86h in the same clock as `sel_toggle` sets the select bit from bit 0 of the written data and ignores the toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_addr | input | 8 | SFR byte address for reads and writes |
| sfr_we | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_re | input | 1 | SFR read strobe |
| sfr_rdata | output | 8 | Registered read data, valid one clock after `sfr_re` |
| sfr_hit | output | 1 | Registered flag: the previous read addressed this block |
| ptr_inc | input | 1 | Increment the selected pointer |
| ptr_load | input | 1 | Load the selected pointer from `load_val` |
| load_val | input | 16 | Value for a 16-bit load |
| sel_toggle | input | 1 | Invert the select bit |
| active_ptr | output | 16 | Currently selected pointer, driven from flops |
| active_sel | output | 1 | Current select bit |

## Verification
The assertions expect `sfr_we`, `ptr_inc`, `ptr_load` and `sel_toggle` to change only between clock edges. They also expect `sfr_addr` to be stable whenever either SFR strobe is high, and they make no assumption about how strobes combine. The stimulus drives every input on the falling edge. Its sweeps cover every address and every data byte, and the mixed phase sets the strobes independently so that collisions between writes, loads, increments and toggles happen often. The expected values come from an arithmetic model in the bench that applies the stated priorities.

// File: rtl/dpu_pkg.sv
package dpu_pkg;
  localparam int unsigned DPU_NUM_PTR   = 2;
  localparam int unsigned DPU_BYTE_W    = 8;
  localparam int unsigned DPU_ADDR_W    = 8;
  localparam logic [7:0]  DPU_PTR_BASE  = 8'h82;
  localparam logic [7:0]  DPU_SEL_ADDR  = 8'h86;
endpackage

// File: rtl/dpu_addr_decode.sv
module dpu_addr_decode #(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned NUM_PTR = 2,
  parameter logic [ADDR_W-1:0] PTR_BASE = 8'h82,
  parameter logic [ADDR_W-1:0] SEL_ADDR = 8'h86
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_PTR-1:0] lo_hit,
  output logic [NUM_PTR-1:0] hi_hit,
  output logic               sel_hit,
  output logic               any_hit
);
  for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr_dec
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(PTR_BASE + 2 * i);
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(PTR_BASE + 2 * i + 1);
    assign lo_hit[i] = (addr == LO_A);
    assign hi_hit[i] = (addr == HI_A);
  end

  assign sel_hit = (addr == SEL_ADDR);
  assign any_hit = (|lo_hit) | (|hi_hit) | sel_hit;
endmodule

// File: rtl/dpu_pointer_reg.sv
module dpu_pointer_reg #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned PTR_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              load_en,
  input  logic [PTR_W-1:0]  load_val,
  input  logic              inc_en,
  output logic [PTR_W-1:0]  q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (wr_lo || wr_hi) begin
      if (wr_lo) q[BYTE_W-1:0]     <= wdata;
      if (wr_hi) q[PTR_W-1:BYTE_W] <= wdata;
    end else if (load_en) begin
      q <= load_val;
    end else if (inc_en) begin
      q <= q + PTR_W'(1);
    end
  end

  assert_inc_step_R5: assert property (@(posedge clk) disable iff (rst)
    (inc_en && !load_en && !wr_lo && !wr_hi) |=> (q == $past(q) + PTR_W'(1)));

  assert_load_full_R6: assert property (@(posedge clk) disable iff (rst)
    (load_en && !wr_lo && !wr_hi) |=> (q == $past(load_val)));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!inc_en && !load_en && !wr_lo && !wr_hi) |=> $stable(q));

  assert_write_wins_lo_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_lo && !wr_hi) |=>
      (q[PTR_W-1:BYTE_W] == $past(q[PTR_W-1:BYTE_W]) && q[BYTE_W-1:0] == $past(wdata)));

  assert_write_wins_hi_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_hi && !wr_lo) |=>
      (q[BYTE_W-1:0] == $past(q[BYTE_W-1:0]) && q[PTR_W-1:BYTE_W] == $past(wdata)));
endmodule

// File: rtl/dpu_select_reg.sv
module dpu_select_reg (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic wr_bit,
  input  logic toggle,
  output logic sel
);
  always_ff @(posedge clk) begin
    if (rst)         sel <= 1'b0;
    else if (wr_en)  sel <= wr_bit;
    else if (toggle) sel <= ~sel;
  end

  assert_toggle_flips_R7: assert property (@(posedge clk) disable iff (rst)
    (toggle && !wr_en) |=> (sel != $past(sel)));

  assert_write_over_toggle_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && toggle) |=> (sel == $past(wr_bit)));
endmodule

// File: rtl/dual_pointer_unit.sv
module dual_pointer_unit
  import dpu_pkg::*;
#(
  parameter int unsigned BYTE_W = DPU_BYTE_W,
  parameter int unsigned ADDR_W = DPU_ADDR_W,
  parameter logic [ADDR_W-1:0] PTR_BASE = DPU_PTR_BASE,
  parameter logic [ADDR_W-1:0] SEL_ADDR = DPU_SEL_ADDR,
  localparam int unsigned PTR_W   = 2 * BYTE_W,
  localparam int unsigned NUM_PTR = DPU_NUM_PTR
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic              sfr_we,
  input  logic [BYTE_W-1:0] sfr_wdata,
  input  logic              sfr_re,
  output logic [BYTE_W-1:0] sfr_rdata,
  output logic              sfr_hit,
  input  logic              ptr_inc,
  input  logic              ptr_load,
  input  logic [PTR_W-1:0]  load_val,
  input  logic              sel_toggle,
  output logic [PTR_W-1:0]  active_ptr,
  output logic              active_sel
);
  logic [NUM_PTR-1:0] lo_hit, hi_hit;
  logic               sel_hit, any_hit;
  logic               sel_q;
  logic [PTR_W-1:0]   ptr_q [NUM_PTR];
  logic [BYTE_W-1:0]  rd_c;

  dpu_addr_decode #(
    .ADDR_W(ADDR_W), .NUM_PTR(NUM_PTR), .PTR_BASE(PTR_BASE), .SEL_ADDR(SEL_ADDR)
  ) u_decode (
    .addr(sfr_addr), .lo_hit(lo_hit), .hi_hit(hi_hit),
    .sel_hit(sel_hit), .any_hit(any_hit)
  );

  dpu_select_reg u_select (
    .clk(clk), .rst(rst),
    .wr_en(sfr_we && sel_hit), .wr_bit(sfr_wdata[0]),
    .toggle(sel_toggle), .sel(sel_q)
  );

  for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
    logic mine;
    assign mine = (sel_q == 1'(i));
    dpu_pointer_reg #(.BYTE_W(BYTE_W)) u_ptr (
      .clk(clk), .rst(rst),
      .wr_lo(sfr_we && lo_hit[i]), .wr_hi(sfr_we && hi_hit[i]),
      .wdata(sfr_wdata),
      .load_en(ptr_load && mine), .load_val(load_val),
      .inc_en(ptr_inc && mine),
      .q(ptr_q[i])
    );
  end

  always_comb begin
    rd_c = '0;
    for (int i = 0; i < NUM_PTR; i++) begin
      if (lo_hit[i]) rd_c = ptr_q[i][BYTE_W-1:0];
      if (hi_hit[i]) rd_c = ptr_q[i][PTR_W-1:BYTE_W];
    end
    if (sel_hit) rd_c = {{(BYTE_W-1){1'b0}}, sel_q};
  end

  always_ff @(posedge clk) begin
    if (rst || !sfr_re) begin
      sfr_rdata <= '0;
      sfr_hit   <= 1'b0;
    end else begin
      sfr_rdata <= rd_c;
      sfr_hit   <= any_hit;
    end
  end

  assign active_ptr = sel_q ? ptr_q[1] : ptr_q[0];
  assign active_sel = sel_q;

  assert_sel_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (sfr_re && sel_hit) |=> (sfr_rdata[BYTE_W-1:1] == '0 && sfr_hit));

  assert_unmapped_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (sfr_re && !any_hit) |=> (sfr_rdata == '0 && !sfr_hit));

  assert_idle_read_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (!sfr_re) |=> (sfr_rdata == '0 && !sfr_hit));

  assert_other_ptr_untouched_R6: assert property (@(posedge clk) disable iff (rst)
    (!sfr_we && !sel_toggle) |=> (sel_q ? $stable(ptr_q[0]) : $stable(ptr_q[1])));
endmodule

// File: tb/dual_pointer_unit_tb.sv
module dual_pointer_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  sfr_addr;
  logic        sfr_we;
  logic [7:0]  sfr_wdata;
  logic        sfr_re;
  logic [7:0]  sfr_rdata;
  logic        sfr_hit;
  logic        ptr_inc;
  logic        ptr_load;
  logic [15:0] load_val;
  logic        sel_toggle;
  logic [15:0] active_ptr;
  logic        active_sel;

  int total = 0;
  int bad   = 0;

  logic [15:0] m_ptr [2];
  logic        m_sel;
  logic [31:0] rng = 32'h1234_5678;

  always #2.5 clk = ~clk;

  dual_pointer_unit u_dut (
    .clk(clk), .rst(rst), .sfr_addr(sfr_addr), .sfr_we(sfr_we),
    .sfr_wdata(sfr_wdata), .sfr_re(sfr_re), .sfr_rdata(sfr_rdata),
    .sfr_hit(sfr_hit), .ptr_inc(ptr_inc), .ptr_load(ptr_load),
    .load_val(load_val), .sel_toggle(sel_toggle),
    .active_ptr(active_ptr), .active_sel(active_sel)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model_rd(input logic [7:0] a);
    case (a)
      8'h82: return m_ptr[0][7:0];
      8'h83: return m_ptr[0][15:8];
      8'h84: return m_ptr[1][7:0];
      8'h85: return m_ptr[1][15:8];
      8'h86: return {7'b0, m_sel};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic model_hit(input logic [7:0] a);
    return (a >= 8'h82 && a <= 8'h86);
  endfunction

  // One clock: drive after a falling edge, model at the rising edge, check at the next falling edge.
  task automatic cyc(input string tag, input logic we, input logic [7:0] a,
                     input logic [7:0] wd, input logic re, input logic inc,
                     input logic ld, input logic [15:0] lv, input logic tog);
    logic [7:0]  exp_rd;
    logic        exp_hit;
    logic [15:0] nxt [2];
    logic        nsel;
    sfr_we = we; sfr_addr = a; sfr_wdata = wd; sfr_re = re;
    ptr_inc = inc; ptr_load = ld; load_val = lv; sel_toggle = tog;
    exp_rd  = re ? model_rd(a) : 8'h00;
    exp_hit = re && model_hit(a);
    for (int i = 0; i < 2; i++) begin
      logic wlo, whi;
      wlo = we && (a == 8'(8'h82 + 2 * i));
      whi = we && (a == 8'(8'h83 + 2 * i));
      nxt[i] = m_ptr[i];
      if (wlo || whi) begin
        if (wlo) nxt[i][7:0]  = wd;
        if (whi) nxt[i][15:8] = wd;
      end else if (m_sel == 1'(i)) begin
        if (ld)       nxt[i] = lv;
        else if (inc) nxt[i] = m_ptr[i] + 16'd1;
      end
    end
    nsel = m_sel;
    if (we && a == 8'h86) nsel = wd[0];
    else if (tog)         nsel = ~m_sel;
    @(posedge clk);
    m_ptr[0] = nxt[0]; m_ptr[1] = nxt[1]; m_sel = nsel;
    @(negedge clk);
    check({tag, " R4 active_ptr"}, 32'(active_ptr), 32'(m_ptr[m_sel]));
    check({tag, " select"}, 32'(active_sel), 32'(m_sel));
    check({tag, " rdata"}, 32'(sfr_rdata), 32'(exp_rd));
    check({tag, " hit"}, 32'(sfr_hit), 32'(exp_hit));
    sfr_we = 0; sfr_re = 0; ptr_inc = 0; ptr_load = 0; sel_toggle = 0;
  endtask

  task automatic wr(input string tag, input logic [7:0] a, input logic [7:0] d);
    cyc(tag, 1, a, d, 0, 0, 0, 16'h0, 0);
  endtask

  task automatic rd(input string tag, input logic [7:0] a);
    cyc(tag, 0, a, 8'h00, 1, 0, 0, 16'h0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1; sfr_we = 0; sfr_addr = 0; sfr_wdata = 0; sfr_re = 0;
    ptr_inc = 0; ptr_load = 0; load_val = 0; sel_toggle = 0;
    m_ptr[0] = 16'h0; m_ptr[1] = 16'h0; m_sel = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1: reset values
    check("R1 active_ptr", 32'(active_ptr), 32'h0);
    check("R1 select", 32'(active_sel), 32'h0);
    check("R1 rdata", 32'(sfr_rdata), 32'h0);
    check("R1 hit", 32'(sfr_hit), 32'h0);
    rd("R1 p0lo", 8'h82); rd("R1 p1hi", 8'h85); rd("R1 sel", 8'h86);

    // R2: every byte value into every pointer byte, read back
    for (int a = 8'h82; a <= 8'h85; a++)
      for (int v = 0; v < 256; v++) begin
        wr("R2 write", 8'(a), 8'(v));
        rd("R2 readback", 8'(a));
      end

    // R3: all write values to the select register
    for (int v = 0; v < 256; v++) begin
      wr("R3 sel write", 8'h86, 8'(v));
      rd("R3 sel read", 8'h86);
    end

    // R9: every address read; unmapped ones return zero
    for (int a = 0; a < 256; a++) rd("R9 sweep", 8'(a));

    // R5: wrap and carry on both pointers
    for (int p = 0; p < 2; p++) begin
      wr("R5 sel", 8'h86, 8'(p));
      cyc("R5 preset", 0, 8'h00, 8'h00, 0, 0, 1, 16'hFFFE, 0);
      for (int k = 0; k < 4; k++) cyc("R5 wrap", 0, 8'h00, 8'h00, 0, 1, 0, 16'h0, 0);
      cyc("R5 preset", 0, 8'h00, 8'h00, 0, 0, 1, 16'h12FF, 0);
      cyc("R5 carry", 0, 8'h00, 8'h00, 0, 1, 0, 16'h0, 0);
      rd("R5 carry hi", 8'(8'h83 + 2 * p));
      for (int k = 0; k < 300; k++) cyc("R5 run", 0, 8'h00, 8'h00, 0, 1, 0, 16'h0, 0);
    end

    // R6: load beats increment, other pointer unchanged
    cyc("R6 load+inc", 0, 8'h00, 8'h00, 0, 1, 1, 16'hBEEF, 0);
    rd("R6 other lo", 8'h82); rd("R6 other hi", 8'h83);

    // R7: toggling flips selection; same-cycle inc uses old pointer
    cyc("R7 toggle+inc", 0, 8'h00, 8'h00, 0, 1, 0, 16'h0, 1);
    cyc("R7 toggle", 0, 8'h00, 8'h00, 0, 0, 0, 16'h0, 1);

    // R8: write to selected pointer byte with inc/load same clock
    wr("R8 sel0", 8'h86, 8'h00);
    cyc("R8 wr lo+inc", 1, 8'h82, 8'h5A, 0, 1, 0, 16'h0, 0);
    cyc("R8 wr hi+load", 1, 8'h83, 8'hA5, 0, 0, 1, 16'h7777, 0);
    rd("R8 read lo", 8'h82); rd("R8 read hi", 8'h83);

    // R10: select write beats toggle
    cyc("R10 wr1+tog", 1, 8'h86, 8'h01, 0, 0, 0, 16'h0, 1);
    cyc("R10 wr1+tog", 1, 8'h86, 8'hFF, 0, 0, 0, 16'h0, 1);
    cyc("R10 wr0+tog", 1, 8'h86, 8'hFE, 0, 0, 0, 16'h0, 1);

    // Mixed stimulus: every strobe independent, collisions frequent (R8 R10)
    for (int k = 0; k < 4000; k++) begin
      logic [7:0] a;
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      a = 8'h80 + 8'(rng[2:0]);
      cyc("R8 mixed", rng[3], a, rng[15:8], rng[4], rng[5], rng[6] & rng[7],
          rng[31:16], rng[16]);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule